// File: doc/BRIEF.md
# RMII Read-Reply Frame Transmitter

This block turns a single register read result into a complete Ethernet frame on a two-bit reduced media-independent transmit interface. When a read request arrives while the transmitter is idle, it captures the read data and sends a fixed-length frame. The frame starts with the preamble and start delimiter. Next come the destination address, the source address and the EtherType, then a payload that carries the read data and is padded with zeros to the Ethernet minimum. The frame ends with a CRC-32 check sequence. A fixed quiet gap follows before the transmitter accepts another request.

One clock cycle carries one dibit, so the clock is the 50 MHz interface reference clock. The addresses, the EtherType, the data width, the useful payload length, the minimum payload, the preamble length and the gap length are all parameters. A write request never produces a frame. The block holds at most one reply, and it drops a request that arrives while it is busy.

Top module: `rmii_reply_tx`

## Requirements
- R1: After reset, tx_en_o is 0, txd_o is 2'b00 and busy_o is 0.
- R2: A request with req_valid_i=1 and req_write_i=0 while busy_o=0 is accepted. tx_en_o is 1 from the next cycle for exactly 288 consecutive cycles (72 bytes) with the default parameters.
- R3: Each byte goes out as four dibits, bits [1:0] first and bits [7:6] last.
- R4: The frame opens with 7 bytes of 8'h55 followed by one byte of 8'hD5.
- R5: After the delimiter come the 6 destination address bytes (DST_MAC, most significant byte first), then the 6 source address bytes (SRC_MAC, most significant first), then ETH_TYPE with the high byte first.
- R6: The payload area is max(PAYLOAD_BYTES, 46) bytes. Its first byte is req_data_i[15:8] and its second byte is req_data_i[7:0], both captured at acceptance. Every other payload byte is 8'h00.
- R7: The last 4 bytes are the check sequence: a CRC-32 over the bytes from the destination address through the last padding byte, using reflected polynomial 32'hEDB88320, initial value all ones and a final inversion. It is sent least significant byte first.
- R8: A request with req_write_i=1 starts no frame, and busy_o stays 0.
- R9: busy_o is 1 from the cycle after acceptance until the gap ends. Any request made while busy_o=1 is dropped and starts no later frame.
- R10: After the last check-sequence dibit, tx_en_o is 0 and busy_o is 1 for exactly 48 cycles (12 byte times), then busy_o returns to 0.
- R11: txd_o is 2'b00 in every cycle in which tx_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dibit clock, one dibit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 marks a write request (no reply), 0 marks a read |
| req_data_i | input | DATA_W | Read data to be returned |
| busy_o | output | 1 | Transmitter cannot take a request |
| tx_en_o | output | 1 | Transmit enable |
| txd_o | output | 2 | Transmit dibit |

## Verification
The bench keeps the default data width of 16, payload of 5 bytes and minimum of 46. It sets every byte of both addresses and of the EtherType to a different value, such as 8'h0A..8'h0F and 8'hC1..8'hC6. A swapped, repeated or misplaced header byte therefore changes the observed dibit stream. Because the payload defaults leave 44 bytes of padding, the check sequence covers a long run of zeros after the data. With a gap of 12 bytes, the 48-cycle quiet window is short enough to measure exactly between back-to-back replies.

// File: rtl/rmii_reply_pkg.sv
package rmii_reply_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

  // Advance a reflected CRC-32 by one byte, low bit first.
  function automatic logic [31:0] crc32_add_byte(input logic [31:0] crc_in,
                                                 input logic [7:0]  data);
    logic [31:0] r;
    r = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ data[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else                r = r >> 1;
    end
    return r;
  endfunction

  // Pick dibit number idx of a byte (0 = bits [1:0]).
  function automatic logic [1:0] byte_dibit(input logic [7:0] b,
                                            input logic [1:0] idx);
    return b[{idx, 1'b0} +: 2];
  endfunction

endpackage

// File: rtl/rmii_tx_seq.sv
module rmii_tx_seq
  import rmii_reply_pkg::*;
#(
  parameter int TOTAL_BYTES = 72,
  parameter int GAP_CYC     = 48,
  localparam int POS_W      = $clog2(TOTAL_BYTES),
  localparam int GCNT_W     = $clog2(GAP_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output tx_state_e        state_o,
  output logic [POS_W-1:0] pos_o,
  output logic [1:0]       dib_o,
  output logic             byte_done_o
);

  tx_state_e          state_q;
  logic [POS_W-1:0]   pos_q;
  logic [1:0]         dib_q;
  logic [GCNT_W-1:0]  gcnt_q;
  logic               last_dibit;

  assign byte_done_o = (state_q == ST_SEND) && (dib_q == 2'd3);
  assign last_dibit  = byte_done_o && (pos_q == POS_W'(TOTAL_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      dib_q   <= '0;
      gcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SEND;
            pos_q   <= '0;
            dib_q   <= '0;
          end
        end
        ST_SEND: begin
          dib_q <= dib_q + 2'd1;
          if (last_dibit) begin
            state_q <= ST_GAP;
            gcnt_q  <= '0;
          end else if (byte_done_o) begin
            pos_q <= pos_q + POS_W'(1);
          end
        end
        ST_GAP: begin
          if (gcnt_q == GCNT_W'(GAP_CYC - 1)) state_q <= ST_IDLE;
          else                                gcnt_q  <= gcnt_q + GCNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign dib_o   = dib_q;

endmodule

// File: rtl/rmii_byte_mux.sv
module rmii_byte_mux #(
  parameter logic [47:0] DST_MAC    = 48'h0,
  parameter logic [47:0] SRC_MAC    = 48'h0,
  parameter logic [15:0] ETH_TYPE   = 16'h0,
  parameter int          DATA_W     = 16,
  parameter int          PRE_BYTES  = 7,
  parameter int          PAD_BYTES  = 46,
  parameter int          POS_W      = 7,
  localparam int         HDR_BYTES  = 14,
  localparam int         HDR_BITS   = HDR_BYTES * 8,
  localparam int         DATA_BYTES = DATA_W / 8,
  localparam int         BODY_START = PRE_BYTES + 1,
  localparam int         PAY_START  = BODY_START + HDR_BYTES,
  localparam int         FCS_START  = PAY_START + PAD_BYTES
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [31:0]       crc_i,
  output logic [7:0]        byte_o,
  output logic              in_body_o,
  output logic              in_fcs_o
);

  localparam logic [HDR_BITS-1:0] HDR_VEC = {DST_MAC, SRC_MAC, ETH_TYPE};

  int p;
  int k;

  always_comb begin
    p         = int'(pos_i);
    k         = 0;
    byte_o    = 8'h00;
    in_body_o = (p >= BODY_START) && (p < FCS_START);
    in_fcs_o  = (p >= FCS_START);
    if (p < PRE_BYTES) begin
      byte_o = 8'h55;
    end else if (p == PRE_BYTES) begin
      byte_o = 8'hD5;
    end else if (p < PAY_START) begin
      k      = p - BODY_START;
      byte_o = HDR_VEC[HDR_BITS - 1 - 8 * k -: 8];
    end else if (p < FCS_START) begin
      k = p - PAY_START;
      if (k < DATA_BYTES) byte_o = data_i[DATA_W - 1 - 8 * k -: 8];
    end else begin
      k      = p - FCS_START;
      byte_o = ~crc_i[8 * k +: 8];
    end
  end

endmodule

// File: rtl/rmii_crc32.sv
module rmii_crc32
  import rmii_reply_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init_i,
  input  logic        step_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init_i) crc_q <= CRC_SEED;
    else if (step_i)   crc_q <= crc32_add_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/rmii_reply_tx.sv
module rmii_reply_tx
  import rmii_reply_pkg::*;
#(
  parameter logic [47:0] DST_MAC        = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC        = 48'h02_00_00_00_00_02,
  parameter logic [15:0] ETH_TYPE       = 16'h88B5,
  parameter int          DATA_W         = 16,
  parameter int          PAYLOAD_BYTES  = 5,
  parameter int          MIN_PAYLOAD    = 46,
  parameter int          PREAMBLE_BYTES = 7,
  parameter int          GAP_BYTES      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              tx_en_o,
  output logic [1:0]        txd_o
);

  localparam int PAD_BYTES   = (PAYLOAD_BYTES > MIN_PAYLOAD) ? PAYLOAD_BYTES : MIN_PAYLOAD;
  localparam int TOTAL_BYTES = PREAMBLE_BYTES + 1 + 14 + PAD_BYTES + 4;
  localparam int FRAME_CYC   = TOTAL_BYTES * 4;
  localparam int GAP_CYC     = GAP_BYTES * 4;
  localparam int POS_W       = $clog2(TOTAL_BYTES);

  tx_state_e         state;
  logic [POS_W-1:0]  pos;
  logic [1:0]        dib;
  logic              byte_done;
  logic [7:0]        cur_byte;
  logic              in_body;
  logic              fcs_phase;
  logic [31:0]       crc_q;
  logic [DATA_W-1:0] data_q;

  // Named events, also used by the bound checker.
  logic accept_evt;
  logic crc_step;

  assign accept_evt = req_valid_i && !req_write_i && (state == ST_IDLE);
  assign crc_step   = byte_done && in_body;

  always_ff @(posedge clk) begin
    if (rst)             data_q <= '0;
    else if (accept_evt) data_q <= req_data_i;
  end

  rmii_tx_seq #(
    .TOTAL_BYTES (TOTAL_BYTES),
    .GAP_CYC     (GAP_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (accept_evt),
    .state_o     (state),
    .pos_o       (pos),
    .dib_o       (dib),
    .byte_done_o (byte_done)
  );

  rmii_byte_mux #(
    .DST_MAC   (DST_MAC),
    .SRC_MAC   (SRC_MAC),
    .ETH_TYPE  (ETH_TYPE),
    .DATA_W    (DATA_W),
    .PRE_BYTES (PREAMBLE_BYTES),
    .PAD_BYTES (PAD_BYTES),
    .POS_W     (POS_W)
  ) u_mux (
    .pos_i     (pos),
    .data_i    (data_q),
    .crc_i     (crc_q),
    .byte_o    (cur_byte),
    .in_body_o (in_body),
    .in_fcs_o  (fcs_phase)
  );

  rmii_crc32 u_crc (
    .clk    (clk),
    .rst    (rst),
    .init_i (accept_evt),
    .step_i (crc_step),
    .byte_i (cur_byte),
    .crc_o  (crc_q)
  );

  assign tx_en_o = (state == ST_SEND);
  assign txd_o   = tx_en_o ? byte_dibit(cur_byte, dib) : 2'b00;
  assign busy_o  = (state != ST_IDLE);

endmodule

// File: rtl/rmii_reply_tx_chk.sv
module rmii_reply_tx_chk #(
  parameter int FRAME_CYC = 288,
  parameter int GAP_CYC   = 48
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic        busy,
  input logic        tx_en,
  input logic [1:0]  txd,
  input logic        accept_evt,
  input logic        fcs_phase,
  input logic [31:0] crc_q
);

  logic [15:0] run_cnt;
  logic [15:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      run_cnt <= tx_en ? run_cnt + 16'd1 : 16'd0;
      gap_cnt <= (!tx_en && busy) ? gap_cnt + 16'd1 : 16'd0;
    end
  end

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (tx_en && busy));

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> (run_cnt == 16'(FRAME_CYC)));

  assert_first_dibit_R4: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (txd == 2'b01));

  assert_crc_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (fcs_phase && tx_en && $past(fcs_phase && tx_en)) |-> $stable(crc_q));

  assert_write_no_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !busy) |=> !busy);

  assert_busy_covers_tx_R9: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> busy);

  assert_gap_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_en) |=> !tx_en);

  assert_gap_len_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (gap_cnt == 16'(GAP_CYC)));

  assert_txd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (txd == 2'b00));

endmodule

bind rmii_reply_tx rmii_reply_tx_chk #(
  .FRAME_CYC (FRAME_CYC),
  .GAP_CYC   (GAP_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid_i),
  .req_write  (req_write_i),
  .busy       (busy_o),
  .tx_en      (tx_en_o),
  .txd        (txd_o),
  .accept_evt (accept_evt),
  .fcs_phase  (fcs_phase),
  .crc_q      (crc_q)
);

// File: tb/sim_rmii_reply_tx.sv
module sim_rmii_reply_tx;

  localparam int CLK_PERIOD = 20;
  localparam logic [47:0] T_DST  = 48'h0A_0B_0C_0D_0E_0F;
  localparam logic [47:0] T_SRC  = 48'hC1_C2_C3_C4_C5_C6;
  localparam logic [15:0] T_TYPE = 16'h88B5;
  localparam int EXP_FRAME = (8 + 14 + 46 + 4) * 4;
  localparam int EXP_GAP   = 12 * 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid_i;
  logic        req_write_i;
  logic [15:0] req_data_i;
  logic        busy_o;
  logic        tx_en_o;
  logic [1:0]  txd_o;

  int   n_checks = 0;
  int   n_errs   = 0;
  bit   done     = 0;
  logic [1:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rmii_reply_tx #(
    .DST_MAC  (T_DST),
    .SRC_MAC  (T_SRC),
    .ETH_TYPE (T_TYPE)
  ) u0 (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_data_i  (req_data_i),
    .busy_o      (busy_o),
    .tx_en_o     (tx_en_o),
    .txd_o       (txd_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Build the expected frame bit by bit and queue its dibits.
  task automatic push_frame(input logic [15:0] d);
    logic [7:0]  fr[$];
    logic [31:0] c;
    logic [31:0] fcs;
    for (int i = 0; i < 7; i++) fr.push_back(8'h55);
    fr.push_back(8'hD5);
    for (int i = 5; i >= 0; i--) fr.push_back(T_DST[8*i +: 8]);
    for (int i = 5; i >= 0; i--) fr.push_back(T_SRC[8*i +: 8]);
    fr.push_back(T_TYPE[15:8]);
    fr.push_back(T_TYPE[7:0]);
    fr.push_back(d[15:8]);
    fr.push_back(d[7:0]);
    for (int i = 0; i < 44; i++) fr.push_back(8'h00);
    c = 32'hFFFF_FFFF;
    for (int i = 8; i < fr.size(); i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ fr[i][b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    fcs = ~c;
    for (int i = 0; i < 4; i++) fr.push_back(fcs[8*i +: 8]);
    foreach (fr[i])
      for (int q = 0; q < 4; q++) exp_q.push_back(fr[i][2*q +: 2]);
  endtask

  task automatic send_req(input logic [15:0] d, input logic wr);
    @(posedge clk); #1;
    req_data_i  = d;
    req_write_i = wr;
    req_valid_i = 1'b1;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic read_reply(input logic [15:0] d);
    wait_idle();
    push_frame(d);
    send_req(d, 1'b0);
  endtask

  // Watch n cycles and count tx_en and busy cycles.
  task automatic watch(input int n, output int tx_cyc, output int busy_cyc);
    tx_cyc = 0;
    busy_cyc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_en_o) tx_cyc++;
      if (busy_o)  busy_cyc++;
    end
  endtask

  // Monitor: pops the scoreboard as dibits appear.
  int run_len = 0;
  int gap_len = 0;
  bit in_gap  = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (tx_en_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected dibit", txd_o, 0);
        end else begin
          logic [1:0] e;
          int         by;
          string      rq;
          e  = exp_q.pop_front();
          by = run_len / 4;
          rq = (by < 8) ? "R4" : (by < 22) ? "R5" : (by < 68) ? "R6" : "R7";
          check(txd_o == e, rq, $sformatf("dibit %0d", run_len), txd_o, e);
          if (run_len == 31)
            check(txd_o == 2'b11, "R3", "delimiter top dibit", txd_o, 2'b11);
        end
        run_len++;
      end else begin
        check(txd_o == 2'b00, "R11", "txd while idle", txd_o, 0);
        if (run_len > 0) begin
          check(run_len == EXP_FRAME, "R2", "frame length", run_len, EXP_FRAME);
          check(exp_q.size() == 0, "R2", "dibits left", exp_q.size(), 0);
          run_len = 0;
          in_gap  = 1;
          gap_len = 0;
        end
        if (in_gap) begin
          if (busy_o) gap_len++;
          else begin
            check(gap_len == EXP_GAP, "R10", "gap length", gap_len, EXP_GAP);
            in_gap = 0;
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int tx_c;
    int busy_c;
    rst = 1'b1;
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
    req_data_i  = 16'h0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(tx_en_o == 1'b0, "R1", "tx_en in reset", tx_en_o, 0);
    check(busy_o == 1'b0,  "R1", "busy in reset", busy_o, 0);
    check(txd_o == 2'b00,  "R1", "txd in reset", txd_o, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(tx_en_o == 1'b0 && busy_o == 1'b0, "R1", "idle after reset",
          {tx_en_o, busy_o}, 0);

    // Several data patterns, back to back (R2, R5, R6, R7, R10).
    read_reply(16'h1234);
    read_reply(16'h0000);
    read_reply(16'hFFFF);
    read_reply(16'hA5C3);
    wait_idle();

    // Write request: no frame at all (R8).
    send_req(16'hBEEF, 1'b1);
    watch(400, tx_c, busy_c);
    check(tx_c == 0,   "R8", "tx cycles after write", tx_c, 0);
    check(busy_c == 0, "R8", "busy cycles after write", busy_c, 0);

    // Request in the middle of a frame is dropped (R9).
    read_reply(16'h5A5A);
    repeat (40) @(posedge clk);
    #1;
    send_req(16'h0F0F, 1'b0);
    wait_idle();
    watch(400, tx_c, busy_c);
    check(tx_c == 0, "R9", "frame from request during send", tx_c, 0);

    // Request during the gap is dropped (R10).
    read_reply(16'h00FF);
    while (!(busy_o && !tx_en_o)) begin
      @(posedge clk); #1;
    end
    repeat (10) @(posedge clk);
    #1;
    send_req(16'h7777, 1'b0);
    wait_idle();
    watch(400, tx_c, busy_c);
    check(tx_c == 0, "R10", "frame from request during gap", tx_c, 0);

    // Final pair back to back, gap measured by the monitor (R10).
    read_reply(16'h1111);
    read_reply(16'h8001);
    wait_idle();
    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule